// File: doc/BRIEF.md
# Four-Channel Single-Transfer DMA Controller

This block moves data between peripherals and memory on four independent channels. Software sets up each channel through a narrow 8-bit register bus. Each channel holds a 16-bit current address, a 16-bit remaining count and an 8-bit page value, plus a mode setting and a mask bit.

A peripheral raises its request line, and the controller then issues one memory request per transfer. The memory request carries a 24-bit physical address and a direction flag, and the controller waits for an acknowledge before it advances the channel. When the programmed count runs out, the channel flags terminal count in a status byte and masks itself.

A build parameter selects a word-wide instance. In that instance, addresses count 16-bit units and register ports sit at even bus addresses.

Top module: `legacy_dma4`

## Requirements
- R1: After reset all four channels are masked, the status byte reads 0x00 and `mem_req` is low; raising any `dreq` line causes no memory request.
- R2: Register index 2n holds the address of channel n and index 2n+1 holds its count. Both are 16-bit values reached through one byte-wide port. A single byte-pointer flag, shared by all of these registers, picks the low byte when clear and the high byte when set, and toggles on every read or write of them.
- R3: Any write to index 0x0B clears the byte pointer, so the next address or count access reaches the low byte.
- R4: A count programmed as N-1 yields exactly N memory transfers. On the last one, bit n of the status byte (index 0x08) sets and channel n masks itself, so it stops requesting. After the last transfer the count reads 0xFFFF.
- R5: A write to index 0x0A programs the mode of the channel named in data bits [1:0]. A channel transfers only when bits [7:6] are 01. Bits [3:2] set the direction: 01 drives `mem_write` high (data into memory) and 10 drives it low (data out of memory). A channel with any other value in either field never requests.
- R6: A write to index 0x09 addresses the channel in data bits [1:0]. Data bit 2 set masks that channel and clear unmasks it. A masked channel does not request even while its `dreq` is high.
- R7: In the byte instance `mem_addr` equals {page, address}. The address increments after each acknowledged transfer and wraps from 0xFFFF to 0x0000 without changing the page. The page for channel n is at index 0x10+n.
- R8: Any write to index 0x0C masks every channel, clears the byte pointer and clears all status bits.
- R9: Any write to index 0x0D unmasks all four channels.
- R10: Reading the status byte clears the bits it returned. A terminal count that lands in the same cycle as that read stays set for the next read.
- R11: When several eligible channels request, the lowest-numbered one is served. Arbitration repeats after every single transfer. `dack` is one-hot for the served channel while `mem_req` is high.
- R12: With WORD_MODE=1, `mem_addr` equals {page[7:1], address, 0}, and register index k sits at bus address 2k.
- R13: Once raised, `mem_req` stays high and serves the same channel until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 5+WORD_MODE | Register bus address |
| io_wr | input | 1 | Register write strobe |
| io_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Register read data (combinational) |
| dreq | input | 4 | Per-channel peripheral request |
| dack | output | 4 | Per-channel acknowledge, one-hot during a transfer |
| mem_req | output | 1 | Memory transfer request |
| mem_addr | output | 24 | Physical memory address |
| mem_write | output | 1 | 1: data into memory, 0: data out of memory |
| mem_ack | input | 1 | Memory acknowledge, ends the transfer |

## Verification
The sensitive coincidence is a terminal count arriving in the same clock edge as a status read. A bit set by that transfer must not be wiped by a read that never returned it. The bench provokes this by holding back the memory acknowledge and then raising `mem_ack` together with a status read strobe. It judges the result from two values: the first read shows only the older pending bit, and a second read shows only the newly finished channel.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int CH_W   = 2;
  localparam int NCH    = 1 << CH_W;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int PAGE_W = 8;
  localparam int PHYS_W = CNT_W + PAGE_W;
  localparam int IDX_W  = 5;

  localparam logic [IDX_W-1:0] IDX_STATUS  = 5'h08;
  localparam logic [IDX_W-1:0] IDX_MASK1   = 5'h09;
  localparam logic [IDX_W-1:0] IDX_MODE    = 5'h0A;
  localparam logic [IDX_W-1:0] IDX_CLRBP   = 5'h0B;
  localparam logic [IDX_W-1:0] IDX_MCLR    = 5'h0C;
  localparam logic [IDX_W-1:0] IDX_CLRMASK = 5'h0D;

  localparam logic [1:0] DIR_TO_MEM   = 2'b01;
  localparam logic [1:0] DIR_FROM_MEM = 2'b10;
  localparam logic [1:0] XMODE_SINGLE = 2'b01;

  typedef enum logic {XF_IDLE, XF_BUSY} xf_state_e;

  function automatic logic [CNT_W-1:0] addr_step(input logic [CNT_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c - 1'b1;
  endfunction

  function automatic logic cnt_last(input logic [CNT_W-1:0] c);
    return c == '0;
  endfunction

  function automatic logic mode_runs(input logic [1:0] xmode, input logic [1:0] dir);
    return (xmode == XMODE_SINGLE) && ((dir == DIR_TO_MEM) || (dir == DIR_FROM_MEM));
  endfunction

  function automatic logic [PHYS_W-1:0] phys_addr(input logic [PAGE_W-1:0] page,
                                                  input logic [CNT_W-1:0] a,
                                                  input logic word);
    if (word) return {page[PAGE_W-1:1], a, 1'b0};
    else      return {page, a};
  endfunction
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr_i,
  input  logic              ld_addr_lo_i,
  input  logic              ld_addr_hi_i,
  input  logic              ld_cnt_lo_i,
  input  logic              ld_cnt_hi_i,
  input  logic              ld_page_i,
  input  logic              ld_mode_i,
  input  logic              mask_set_i,
  input  logic              mask_clr_i,
  input  logic              step_i,
  input  logic              status_rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              mask_o,
  output logic              run_ok_o,
  output logic              to_mem_o,
  output logic              tc_o,
  output logic              tc_hit_o
);
  logic [CNT_W-1:0]  addr_q, cnt_q;
  logic [PAGE_W-1:0] page_q;
  logic [1:0]        xmode_q, dir_q;
  logic              mask_q, tc_q;
  logic              tc_hit;

  assign tc_hit = step_i && cnt_last(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n)             addr_q <= '0;
    else if (ld_addr_lo_i)  addr_q[DATA_W-1:0] <= wdata_i;
    else if (ld_addr_hi_i)  addr_q[CNT_W-1:DATA_W] <= wdata_i;
    else if (step_i)        addr_q <= addr_step(addr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (ld_cnt_lo_i)   cnt_q[DATA_W-1:0] <= wdata_i;
    else if (ld_cnt_hi_i)   cnt_q[CNT_W-1:DATA_W] <= wdata_i;
    else if (step_i)        cnt_q <= cnt_step(cnt_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          page_q <= '0;
    else if (ld_page_i)  page_q <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xmode_q <= '0;
      dir_q   <= '0;
    end else if (ld_mode_i) begin
      xmode_q <= wdata_i[7:6];
      dir_q   <= wdata_i[3:2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                mask_q <= 1'b1;
    else if (mclr_i || tc_hit || mask_set_i)   mask_q <= 1'b1;
    else if (mask_clr_i)                       mask_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       tc_q <= 1'b0;
    else if (mclr_i)  tc_q <= 1'b0;
    else              tc_q <= (tc_q && !status_rd_i) || tc_hit;
  end

  assign addr_o   = addr_q;
  assign cnt_o    = cnt_q;
  assign page_o   = page_q;
  assign mask_o   = mask_q;
  assign run_ok_o = !mask_q && mode_runs(xmode_q, dir_q);
  assign to_mem_o = (dir_q == DIR_TO_MEM);
  assign tc_o     = tc_q;
  assign tc_hit_o = tc_hit;

  assert_tc_selfmask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit && !mclr_i |=> mask_q && !run_ok_o);

  assert_tc_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit && !mclr_i |=> tc_q);

  assert_page_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_page_i |=> $stable(page_q));
endmodule

// File: rtl/dmac_prio.sv
module dmac_prio #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign valid_o = |req_i;
endmodule

// File: rtl/dmac_xfer.sv
module dmac_xfer
  import dmac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mclr_i,
  input  logic            grant_valid_i,
  input  logic [CH_W-1:0] grant_idx_i,
  input  logic            mem_ack_i,
  output logic            busy_o,
  output logic [CH_W-1:0] cur_ch_o,
  output logic [NCH-1:0]  step_o,
  output logic [NCH-1:0]  dack_o
);
  xf_state_e       state_q;
  logic [CH_W-1:0] cur_q;
  logic            done;

  assign done = (state_q == XF_BUSY) && mem_ack_i && !mclr_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      cur_q   <= '0;
    end else begin
      case (state_q)
        XF_IDLE: if (grant_valid_i && !mclr_i) begin
          state_q <= XF_BUSY;
          cur_q   <= grant_idx_i;
        end
        XF_BUSY: if (mclr_i || mem_ack_i) state_q <= XF_IDLE;
        default: state_q <= XF_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q == XF_BUSY);
  assign cur_ch_o = cur_q;
  assign step_o   = done ? (NCH'(1) << cur_q) : '0;
  assign dack_o   = busy_o ? (NCH'(1) << cur_q) : '0;

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !mem_ack_i && !mclr_i |=> busy_o && $stable(cur_q));

  assert_dack_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack_o) && ((dack_o != '0) == busy_o));
endmodule

// File: rtl/legacy_dma4.sv
module legacy_dma4
  import dmac_pkg::*;
#(
  parameter bit WORD_MODE = 1'b0,
  localparam int SH = WORD_MODE ? 1 : 0,
  localparam int AW = IDX_W + SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic [NCH-1:0]    dreq,
  output logic [NCH-1:0]    dack,
  output logic              mem_req,
  output logic [PHYS_W-1:0] mem_addr,
  output logic              mem_write,
  input  logic              mem_ack
);
  logic [IDX_W-1:0] idx;
  logic             is_ac, is_page, ac_cnt, ac_access;
  logic [CH_W-1:0]  ac_ch, pg_ch, wd_ch;
  logic             mclr_wr, clrbp_wr, clrmask_wr, mask1_wr, mode_wr, status_rd;
  logic             bp_q;

  logic [CNT_W-1:0]  addr_v [NCH];
  logic [CNT_W-1:0]  cnt_v  [NCH];
  logic [PAGE_W-1:0] page_v [NCH];
  logic [NCH-1:0]    mask_vec, run_ok_vec, to_mem_vec, tc_vec, tc_hit_vec, step_vec;
  logic [NCH-1:0]    eligible, run_ok_d;
  logic              grant_valid, busy;
  logic [CH_W-1:0]   grant_idx, cur_ch;
  logic [CNT_W-1:0]  rd_word;

  assign idx        = io_addr[AW-1:SH];
  assign is_ac      = (idx[IDX_W-1:CH_W+1] == '0);
  assign ac_ch      = idx[CH_W:1];
  assign ac_cnt     = idx[0];
  assign is_page    = (idx[IDX_W-1:CH_W] == 3'b100);
  assign pg_ch      = idx[CH_W-1:0];
  assign wd_ch      = io_wdata[CH_W-1:0];
  assign ac_access  = (io_wr || io_rd) && is_ac;
  assign mclr_wr    = io_wr && (idx == IDX_MCLR);
  assign clrbp_wr   = io_wr && (idx == IDX_CLRBP);
  assign clrmask_wr = io_wr && (idx == IDX_CLRMASK);
  assign mask1_wr   = io_wr && (idx == IDX_MASK1);
  assign mode_wr    = io_wr && (idx == IDX_MODE);
  assign status_rd  = io_rd && (idx == IDX_STATUS);

  always_ff @(posedge clk) begin
    if (!rst_n)                   bp_q <= 1'b0;
    else if (mclr_wr || clrbp_wr) bp_q <= 1'b0;
    else if (ac_access)           bp_q <= !bp_q;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic sel_ac, sel_pg, sel_wd;
    assign sel_ac = io_wr && is_ac && (ac_ch == CH_W'(n));
    assign sel_pg = io_wr && is_page && (pg_ch == CH_W'(n));
    assign sel_wd = (wd_ch == CH_W'(n));

    dmac_chan u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .mclr_i       (mclr_wr),
      .ld_addr_lo_i (sel_ac && !ac_cnt && !bp_q),
      .ld_addr_hi_i (sel_ac && !ac_cnt &&  bp_q),
      .ld_cnt_lo_i  (sel_ac &&  ac_cnt && !bp_q),
      .ld_cnt_hi_i  (sel_ac &&  ac_cnt &&  bp_q),
      .ld_page_i    (sel_pg),
      .ld_mode_i    (mode_wr && sel_wd),
      .mask_set_i   (mask1_wr && sel_wd && io_wdata[2]),
      .mask_clr_i   (clrmask_wr || (mask1_wr && sel_wd && !io_wdata[2])),
      .step_i       (step_vec[n]),
      .status_rd_i  (status_rd),
      .wdata_i      (io_wdata),
      .addr_o       (addr_v[n]),
      .cnt_o        (cnt_v[n]),
      .page_o       (page_v[n]),
      .mask_o       (mask_vec[n]),
      .run_ok_o     (run_ok_vec[n]),
      .to_mem_o     (to_mem_vec[n]),
      .tc_o         (tc_vec[n]),
      .tc_hit_o     (tc_hit_vec[n])
    );
  end

  assign eligible = dreq & run_ok_vec;

  dmac_prio #(.N(NCH)) u_prio (
    .req_i   (eligible),
    .valid_o (grant_valid),
    .idx_o   (grant_idx)
  );

  dmac_xfer u_xfer (
    .clk           (clk),
    .rst_n         (rst_n),
    .mclr_i        (mclr_wr),
    .grant_valid_i (grant_valid),
    .grant_idx_i   (grant_idx),
    .mem_ack_i     (mem_ack),
    .busy_o        (busy),
    .cur_ch_o      (cur_ch),
    .step_o        (step_vec),
    .dack_o        (dack)
  );

  assign mem_req   = busy;
  assign mem_addr  = phys_addr(page_v[cur_ch], addr_v[cur_ch], WORD_MODE);
  assign mem_write = to_mem_vec[cur_ch];

  always_comb begin
    io_rdata = '0;
    rd_word  = ac_cnt ? cnt_v[ac_ch] : addr_v[ac_ch];
    if (is_ac)                    io_rdata = bp_q ? rd_word[CNT_W-1:DATA_W] : rd_word[DATA_W-1:0];
    else if (idx == IDX_STATUS)   io_rdata = {{(DATA_W-NCH){1'b0}}, tc_vec};
    else if (is_page)             io_rdata = page_v[pg_ch];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) run_ok_d <= '0;
    else        run_ok_d <= run_ok_vec;
  end

  assert_grant_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> run_ok_d[cur_ch]);

  assert_mclr_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_wr |=> (&mask_vec) && !bp_q && (tc_vec == '0) && !mem_req);

  assert_clrmask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clrmask_wr && (tc_hit_vec == '0) |=> (mask_vec == '0));

  assert_one_tc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_hit_vec));
endmodule

// File: tb/legacy_dma4_tb.sv
module legacy_dma4_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = !clk;

  logic [4:0] io_addr = '0;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic [3:0] dreq = '0, dack;
  logic       mem_req, mem_write, mem_ack = 1'b0;
  logic [23:0] mem_addr;

  logic [5:0] w_addr = '0;
  logic       w_wr = 1'b0, w_rd = 1'b0;
  logic [7:0] w_wdata = '0, w_rdata;
  logic [3:0] w_dreq = '0, w_dack;
  logic       w_req, w_write, w_ack = 1'b0;
  logic [23:0] w_maddr;

  legacy_dma4 u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dreq(dreq), .dack(dack),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_write(mem_write), .mem_ack(mem_ack));

  legacy_dma4 #(.WORD_MODE(1'b1)) u_dut_w (
    .clk(clk), .rst_n(rst_n), .io_addr(w_addr), .io_wr(w_wr), .io_rd(w_rd),
    .io_wdata(w_wdata), .io_rdata(w_rdata), .dreq(w_dreq), .dack(w_dack),
    .mem_req(w_req), .mem_addr(w_maddr), .mem_write(w_write), .mem_ack(w_ack));

  int checks = 0, errors = 0;
  int rec_n = 0, w_rec_n = 0;
  bit auto_ack = 1'b1;
  logic [23:0] rec_addr [64];
  logic        rec_dir  [64];
  logic [3:0]  rec_dack [64];
  logic [23:0] w_rec_addr [64];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_phys(input logic [7:0] pg, input logic [15:0] a, input bit word);
    int unsigned v;
    if (word) v = (int'(pg & 8'hFE) * 65536) + int'(a) * 2;
    else      v = int'(pg) * 65536 + int'(a);
    return v[23:0];
  endfunction

  // memory responders
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (auto_ack) begin
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
          if (dly == 0) begin
            if (rec_n < 64) begin
              rec_addr[rec_n] = mem_addr;
              rec_dir[rec_n]  = mem_write;
              rec_dack[rec_n] = dack;
            end
            rec_n++;
            mem_ack = 1'b1;
            dly = int'($urandom % 3);
          end else dly--;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (w_ack) w_ack = 1'b0;
      else if (w_req) begin
        if (w_rec_n < 64) w_rec_addr[w_rec_n] = w_maddr;
        w_rec_n++;
        w_ack = 1'b1;
      end
    end
  end

  task automatic wr(input bit sel, input logic [4:0] idx, input logic [7:0] d);
    @(negedge clk);
    if (!sel) begin io_wr = 1'b1; io_addr = idx; io_wdata = d; end
    else begin w_wr = 1'b1; w_addr = {idx, 1'b0}; w_wdata = d; end
    @(negedge clk);
    io_wr = 1'b0; w_wr = 1'b0;
  endtask

  task automatic rd(input bit sel, input logic [4:0] idx, output logic [7:0] d);
    @(negedge clk);
    if (!sel) begin io_rd = 1'b1; io_addr = idx; end
    else begin w_rd = 1'b1; w_addr = {idx, 1'b0}; end
    #2;
    d = sel ? w_rdata : io_rdata;
    @(negedge clk);
    io_rd = 1'b0; w_rd = 1'b0;
  endtask

  task automatic prog(input bit sel, input int ch, input logic [7:0] pg,
                      input logic [15:0] a, input logic [15:0] c, input logic [7:0] mode);
    wr(sel, 5'h0B, 8'h00);
    wr(sel, 5'(2*ch), a[7:0]);
    wr(sel, 5'(2*ch), a[15:8]);
    wr(sel, 5'(2*ch+1), c[7:0]);
    wr(sel, 5'(2*ch+1), c[15:8]);
    wr(sel, 5'(16+ch), pg);
    wr(sel, 5'h0A, mode | 8'(ch));
  endtask

  task automatic wait_recs(input int n);
    for (int i = 0; i < 400 && rec_n < n; i++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 mem_req", 32'(mem_req), 0);
    rd(0, 5'h08, v); chk("R1 status", 32'(v), 0);
    dreq = 4'hF; repeat (10) @(negedge clk); dreq = 4'h0;
    chk("R1 no request", 32'(rec_n), 0);

    // R2 / R3: byte pointer
    prog(0, 1, 8'h00, 16'h1234, 16'hBEEF, 8'h45);
    wr(0, 5'h0B, 0);
    rd(0, 5'h02, v); rd(0, 5'h02, v2);
    chk("R2 addr readback", 32'({v2, v}), 32'h1234);
    rd(0, 5'h03, v); rd(0, 5'h03, v2);
    chk("R2 count readback", 32'({v2, v}), 32'hBEEF);
    wr(0, 5'h0B, 0);
    wr(0, 5'h04, 8'hAA);
    wr(0, 5'h0B, 0);
    wr(0, 5'h04, 8'h55); wr(0, 5'h04, 8'h66);
    wr(0, 5'h0B, 0);
    rd(0, 5'h04, v); rd(0, 5'h04, v2);
    chk("R3 low byte after clear", 32'({v2, v}), 32'h6655);

    // R4 / R5 / R7: ch0, into memory, wrap without page carry
    prog(0, 0, 8'h3C, 16'hFFFE, 16'd2, 8'h44);
    rec_n = 0;
    wr(0, 5'h09, 8'h00);
    dreq = 4'b0001; wait_recs(3); dreq = 4'h0;
    chk("R4 transfer count", 32'(rec_n), 3);
    chk("R7 addr0", 32'(rec_addr[0]), 32'h3CFFFE);
    chk("R7 addr1", 32'(rec_addr[1]), 32'h3CFFFF);
    chk("R7 wrap keeps page", 32'(rec_addr[2]), 32'h3C0000);
    chk("R5 dir to memory", 32'(rec_dir[0]), 1);
    chk("R11 dack ch0", 32'(rec_dack[0]), 32'h1);
    wr(0, 5'h0B, 0);
    rd(0, 5'h01, v); rd(0, 5'h01, v2);
    chk("R4 count after tc", 32'({v2, v}), 32'hFFFF);
    rd(0, 5'h08, v); chk("R4 status bit0", 32'(v), 32'h01);
    rd(0, 5'h08, v); chk("R10 cleared after read", 32'(v), 0);

    // R5: invalid modes never request, from-memory direction
    prog(0, 3, 8'h01, 16'h0100, 16'd0, 8'h80);
    rec_n = 0;
    wr(0, 5'h09, 8'h03);
    dreq = 4'b1000; repeat (12) @(negedge clk);
    chk("R5 block mode idle", 32'(rec_n), 0);
    wr(0, 5'h0A, 8'h4F); repeat (12) @(negedge clk);
    chk("R5 dir 11 idle", 32'(rec_n), 0);
    wr(0, 5'h0A, 8'h4B); wait_recs(1); dreq = 4'h0;
    chk("R5 from-memory runs", 32'(rec_n), 1);
    chk("R5 dir from memory", 32'(rec_dir[0]), 0);

    // R8 / R9: master clear (status bit3 still pending here), clear mask
    wr(0, 5'h0B, 0);
    wr(0, 5'h00, 8'h11);
    wr(0, 5'h0C, 8'h5A);
    rd(0, 5'h08, v); chk("R8 status cleared", 32'(v), 0);
    wr(0, 5'h00, 8'h22); wr(0, 5'h00, 8'h33);
    wr(0, 5'h0B, 0);
    rd(0, 5'h00, v); rd(0, 5'h00, v2);
    chk("R8 pointer cleared", 32'({v2, v}), 32'h3322);
    prog(0, 0, 8'h02, 16'h0040, 16'd0, 8'h44);
    rec_n = 0;
    dreq = 4'b0001; repeat (12) @(negedge clk);
    chk("R8 all masked", 32'(rec_n), 0);
    wr(0, 5'h0D, 8'h00); wait_recs(1); dreq = 4'h0;
    chk("R9 clear mask enables", 32'(rec_n), 1);
    chk("R9 address", 32'(rec_addr[0]), 32'h020040);
    rd(0, 5'h08, v);

    // R6: single mask register
    prog(0, 1, 8'h05, 16'h0800, 16'd0, 8'h45);
    rec_n = 0;
    wr(0, 5'h09, 8'h05);
    dreq = 4'b0010; repeat (12) @(negedge clk);
    chk("R6 masked idle", 32'(rec_n), 0);
    wr(0, 5'h09, 8'h01); wait_recs(1); dreq = 4'h0;
    chk("R6 unmask runs", 32'(rec_n), 1);
    rd(0, 5'h08, v);

    // R11: priority and per-transfer arbitration
    prog(0, 1, 8'h10, 16'h0000, 16'd1, 8'h44);
    prog(0, 2, 8'h20, 16'h0000, 16'd1, 8'h48);
    rec_n = 0;
    wr(0, 5'h09, 8'h01); wr(0, 5'h09, 8'h02);
    dreq = 4'b0110; wait_recs(4); dreq = 4'h0;
    chk("R11 count", 32'(rec_n), 4);
    chk("R11 order0", 32'(rec_dack[0]), 32'h2);
    chk("R11 order1", 32'(rec_dack[1]), 32'h2);
    chk("R11 order2", 32'(rec_dack[2]), 32'h4);
    chk("R11 order3", 32'(rec_addr[3]), 32'h200001);
    rd(0, 5'h08, v); chk("R4 two tc bits", 32'(v), 32'h06);

    // R10: terminal count in the same cycle as a status read
    prog(0, 2, 8'h00, 16'h0000, 16'd0, 8'h48);
    rec_n = 0;
    wr(0, 5'h09, 8'h02);
    dreq = 4'b0100; wait_recs(1); dreq = 4'h0;
    auto_ack = 1'b0;
    prog(0, 1, 8'h00, 16'h0000, 16'd0, 8'h44);
    wr(0, 5'h09, 8'h01);
    dreq = 4'b0010;
    for (int i = 0; i < 50 && !mem_req; i++) @(negedge clk);
    mem_ack = 1'b1; io_rd = 1'b1; io_addr = 5'h08;
    #2 v = io_rdata;
    @(negedge clk);
    mem_ack = 1'b0; io_rd = 1'b0; dreq = 4'h0;
    auto_ack = 1'b1;
    chk("R10 read before tc", 32'(v), 32'h04);
    rd(0, 5'h08, v); chk("R10 same-cycle tc kept", 32'(v), 32'h02);

    // R12: word-wide instance
    prog(1, 1, 8'h12, 16'h8000, 16'd1, 8'h44);
    wr(1, 5'h0B, 0);
    rd(1, 5'h02, v); rd(1, 5'h02, v2);
    chk("R12 spaced readback", 32'({v2, v}), 32'h8000);
    wr(1, 5'h09, 8'h01);
    w_dreq = 4'b0010;
    for (int i = 0; i < 100 && w_rec_n < 2; i++) @(negedge clk);
    repeat (8) @(negedge clk); w_dreq = 4'h0;
    chk("R12 count", 32'(w_rec_n), 2);
    chk("R12 addr0", 32'(w_rec_addr[0]), 32'(exp_phys(8'h12, 16'h8000, 1)));
    chk("R12 addr1", 32'(w_rec_addr[1]), 32'(exp_phys(8'h12, 16'h8001, 1)));

    // random programs
    for (int it = 0; it < 24; it++) begin
      int ch = int'($urandom % 4);
      int cn = int'($urandom % 6);
      logic [7:0]  pg = 8'($urandom);
      logic [15:0] a  = ($urandom % 4 == 0) ? 16'hFFFF - 16'($urandom % 3) : 16'($urandom);
      bit tm = 1'($urandom);
      prog(0, ch, pg, a, 16'(cn), tm ? 8'h44 : 8'h48);
      rec_n = 0;
      wr(0, 5'h09, 8'(ch));
      dreq = 4'(1 << ch); wait_recs(cn + 1); dreq = 4'h0;
      chk("R4 random count", 32'(rec_n), 32'(cn + 1));
      for (int k = 0; k <= cn && k < rec_n; k++) begin
        chk("R7 random addr", 32'(rec_addr[k]), 32'(exp_phys(pg, a + 16'(k), 0)));
        chk("R5 random dir", 32'(rec_dir[k]), 32'(tm));
        chk("R11 random dack", 32'(rec_dack[k]), 32'(1 << ch));
      end
      rd(0, 5'h08, v); chk("R4 random status", 32'(v), 32'(1 << ch));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule